// File: doc/BRIEF.md
# Side-Channel Bit Capture Buffer

This block sits behind the decoder of a consumer digital audio link. Each decoded sub-frame arrives as a one-cycle strobe. The strobe carries the channel-status bit, the user bit and one auxiliary bit. It also carries a flag that marks which of the two sub-frames of a frame it is, and a block-start flag. The block gathers these bits into bytes, least significant bit first in order of arrival, and writes the bytes into a 32-byte register buffer. A host reads the buffer through a byte-addressed, combinational read port.

A two-bit layout code chooses how the buffer is split. Every layout keeps four user bytes. The other layouts are a whole 192-frame channel-status block from one sub-frame, a short channel-status record plus auxiliary bytes, or short channel-status records from both sub-frames. A select bit names the sub-frame to capture. The layout code and the select bit are sampled at each block start and hold for that block. When the host's frequency-compare function is on, the top address bit is forced low, so the upper half of the buffer cannot be reached.

Top module: `csb_top`

## Requirements
- R1: After reset every buffer byte reads 0x00 and `blk_done` is low.
- R2: In every layout, byte k at address k (k = 0..3) holds the user bits of frames 8k..8k+7 of the primary sub-frame, with frame 8k+j in bit j. Addresses 4..7 always read 0x00.
- R3: Layout 0 stores the channel-status bits of frames 0..191 of the primary sub-frame as 24 bytes at addresses 8..31, using the same bit packing as R2.
- R4: Layout 1 stores the channel status of frames 0..63 at addresses 8..15. It stores the auxiliary bits of frames 0..127 of the primary sub-frame at addresses 16..31.
- R5: Layout 2 stores the channel status of frames 0..63 of sub-frame 1 at addresses 8..15 and of sub-frame 2 at addresses 16..23. The user bytes come from sub-frame 1, and the select bit has no effect.
- R6: In layouts 0 and 1 the primary sub-frame is sub-frame 1 when `sub_sel` is 0 and sub-frame 2 when `sub_sel` is 1. `sf_second` is 0 for sub-frame 1 and 1 for sub-frame 2.
- R7: Layout code 3 leaves every buffer byte unchanged and raises no `blk_done` for that block.
- R8: While `freq_cmp_en` is 1, a read of address a returns the byte at address a with bit 4 cleared.
- R9: `blk_done` is high for exactly one cycle. That cycle follows the clock edge that takes in the sub-frame-2 strobe of frame 191 of a block whose layout is not 3.
- R10: A block-start flag, which counts only on a sub-frame-1 strobe, restarts capture at frame 0. Strobes that arrive before the first block start after reset write nothing.
- R11: Changes to `mode_sel` or `sub_sel` after a block start have no effect until the next block start.

Here frame f means the f-th frame after the block start, counted from 0. A block is 192 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle strobe: a decoded sub-frame is present |
| sf_second | input | 1 | 0 = sub-frame 1, 1 = sub-frame 2 |
| blk_start | input | 1 | First frame of a block (valid with a sub-frame-1 strobe) |
| c_bit | input | 1 | Channel-status bit of the sub-frame |
| u_bit | input | 1 | User bit of the sub-frame |
| aux_bit | input | 1 | Auxiliary bit of the sub-frame |
| mode_sel | input | 2 | Buffer layout code, 0..3 |
| sub_sel | input | 1 | Sub-frame select for layouts 0 and 1 |
| freq_cmp_en | input | 1 | Forces read address bit 4 to zero |
| rd_addr | input | 5 | Host read byte address |
| rd_data | output | 8 | Byte at the effective read address |
| blk_done | output | 1 | One-cycle pulse when a block's capture completes |

## Verification
A wrong frame count or a missed restart shows as bytes that have moved or whose bits are rotated, and a misplaced `blk_done`. The pulse error is visible in the cycle after frame 191. The byte error is visible as soon as the host reads back the block. A stuck or wrong lane write-enable shows as stale or overwritten bytes in a region that the layout does or does not own, and the full 32-byte readback after each block exposes it. A layout code or select bit that is not held for the whole block shows when the inputs change mid-block, because bytes then appear at the wrong addresses or from the wrong sub-frame.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam int FRAMES_PER_BLK = 192;
    localparam int BYTE_BITS      = 8;
    localparam int BUF_BYTES      = 32;
    localparam int NUM_LANES      = 4;

    localparam int ADDR_W   = $clog2(BUF_BYTES);
    localparam int FRAME_W  = $clog2(FRAMES_PER_BLK);
    localparam int BITPOS_W = $clog2(BYTE_BITS);

    // Byte counts per region
    localparam int USER_BYTES     = 4;
    localparam int CS_SHORT_BYTES = 8;
    localparam int AUX_BYTES      = 16;

    // Frame limits derived from byte counts
    localparam int USER_FRAMES     = USER_BYTES * BYTE_BITS;
    localparam int CS_SHORT_FRAMES = CS_SHORT_BYTES * BYTE_BITS;
    localparam int AUX_FRAMES      = AUX_BYTES * BYTE_BITS;

    // Region base addresses
    localparam int USER_BASE = 0;
    localparam int CSA_BASE  = 8;
    localparam int CSB_BASE  = 16;
    localparam int AUX_BASE  = 16;

    // Lane identifiers
    localparam int LANE_USER = 0;
    localparam int LANE_CSA  = 1;
    localparam int LANE_CSB  = 2;
    localparam int LANE_AUX  = 3;

    typedef enum logic [1:0] {
        BM_FULL_CS  = 2'd0,
        BM_CS_AUX   = 2'd1,
        BM_DUAL_CS  = 2'd2,
        BM_RESERVED = 2'd3
    } buf_mode_e;

    typedef struct packed {
        logic                 en;
        logic [ADDR_W-1:0]    addr;
        logic [BYTE_BITS-1:0] data;
    } wr_req_t;

    function automatic logic [ADDR_W-1:0] lane_base(input int lane);
        case (lane)
            LANE_USER: lane_base = ADDR_W'(USER_BASE);
            LANE_CSA:  lane_base = ADDR_W'(CSA_BASE);
            LANE_CSB:  lane_base = ADDR_W'(CSB_BASE);
            default:   lane_base = ADDR_W'(AUX_BASE);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] fold_addr(input logic [ADDR_W-1:0] a,
                                                   input logic hide_upper);
        fold_addr = {a[ADDR_W-1] & ~hide_upper, a[ADDR_W-2:0]};
    endfunction

endpackage

// File: rtl/csb_frame_ctl.sv
module csb_frame_ctl
    import csb_pkg::*;
#(
    parameter int FRAMES = FRAMES_PER_BLK
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sf_valid,
    input  logic               sf_second,
    input  logic               blk_start,
    input  logic [1:0]         mode_in,
    input  logic               sel_in,
    output logic [FRAME_W-1:0] frame_idx,
    output buf_mode_e          mode_eff,
    output logic               sel_eff,
    output logic               active,
    output logic               blk_clr,
    output logic               done
);

    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES - 1);

    logic               armed_q;
    logic [FRAME_W-1:0] frame_q;
    buf_mode_e          mode_q;
    logic               sel_q;
    logic               done_q;
    logic               start;
    logic               close_sf;

    assign start    = sf_valid & ~sf_second & blk_start;
    assign close_sf = sf_valid & sf_second & armed_q;

    // Block start applies in the cycle it arrives
    assign frame_idx = start ? '0 : frame_q;
    assign mode_eff  = start ? buf_mode_e'(mode_in) : mode_q;
    assign sel_eff   = start ? sel_in : sel_q;
    assign active    = start | armed_q;
    assign blk_clr   = start;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            frame_q <= '0;
            mode_q  <= BM_FULL_CS;
            sel_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                armed_q <= 1'b1;
                frame_q <= '0;
                mode_q  <= buf_mode_e'(mode_in);
                sel_q   <= sel_in;
            end else if (close_sf) begin
                if (frame_q == LAST_FRAME) begin
                    armed_q <= 1'b0;
                    frame_q <= '0;
                    done_q  <= (mode_q != BM_RESERVED);
                end else begin
                    frame_q <= frame_q + 1'b1;
                end
            end
        end
    end

    p_frame_in_range_r10: assert property (@(posedge clk) disable iff (rst)
        frame_q <= LAST_FRAME);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_second_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(sf_valid && sf_second));

    p_idle_counter_rest_r10: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> frame_q == '0);

endmodule

// File: rtl/csb_lane.sv
module csb_lane
    import csb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      take,
    input  logic                      bit_in,
    input  logic [BITPOS_W-1:0]       bit_pos,
    input  logic [FRAME_W-BITPOS_W-1:0] byte_idx,
    output wr_req_t                   wr
);

    localparam logic [BITPOS_W-1:0] TOP_POS = BITPOS_W'(BYTE_BITS - 1);

    // Holds the bits already received for the byte being assembled
    logic [BYTE_BITS-2:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (take) begin
            sr_q <= {bit_in, sr_q[BYTE_BITS-2:1]};
        end else if (clr) begin
            sr_q <= '0;
        end
    end

    always_comb begin
        wr.en   = take && (bit_pos == TOP_POS);
        wr.addr = BASE + ADDR_W'(byte_idx);
        wr.data = {bit_in, sr_q};
    end

endmodule

// File: rtl/csb_store.sv
module csb_store
    import csb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t [NUM_LANES-1:0]       reqs,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          hide_upper,
    output logic [BYTE_BITS-1:0]          rd_data
);

    logic [BYTE_BITS-1:0] mem_q [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                for (int l = 0; l < NUM_LANES; l++) begin
                    if (reqs[l].en && (reqs[l].addr == ADDR_W'(i)))
                        mem_q[i] <= reqs[l].data;
                end
            end
        end
    end

    assign rd_data = mem_q[fold_addr(rd_addr, hide_upper)];

    // Lanes never target the same byte in one cycle (R5)
    for (genvar a = 0; a < NUM_LANES; a++) begin : g_pair_a
        for (genvar b = a + 1; b < NUM_LANES; b++) begin : g_pair_b
            p_no_addr_clash_r5: assert property (@(posedge clk) disable iff (rst)
                (reqs[a].en && reqs[b].en) |-> (reqs[a].addr != reqs[b].addr));
        end
    end

    // The gap after the user bytes is never written (R2)
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_gap
        p_gap_unwritten_r2: assert property (@(posedge clk) disable iff (rst)
            reqs[l].en |-> (reqs[l].addr < ADDR_W'(USER_BYTES) ||
                            reqs[l].addr >= ADDR_W'(CSA_BASE)));
    end

endmodule

// File: rtl/csb_top.sv
module csb_top
    import csb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sf_valid,
    input  logic                 sf_second,
    input  logic                 blk_start,
    input  logic                 c_bit,
    input  logic                 u_bit,
    input  logic                 aux_bit,
    input  logic [1:0]           mode_sel,
    input  logic                 sub_sel,
    input  logic                 freq_cmp_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 blk_done
);

    localparam logic [FRAME_W-1:0] LIM_USER  = FRAME_W'(USER_FRAMES);
    localparam logic [FRAME_W-1:0] LIM_SHORT = FRAME_W'(CS_SHORT_FRAMES);
    localparam logic [FRAME_W-1:0] LIM_AUX   = FRAME_W'(AUX_FRAMES);
    localparam logic [FRAME_W-1:0] LIM_FULL  = FRAME_W'(FRAMES_PER_BLK - 1);

    logic [FRAME_W-1:0] frame_idx;
    buf_mode_e          mode_eff;
    logic               sel_eff;
    logic               active;
    logic               blk_clr;
    logic               primary;
    logic               live;
    logic               csa_in_range;
    logic [NUM_LANES-1:0] take;
    logic [NUM_LANES-1:0] lane_bit;
    wr_req_t [NUM_LANES-1:0] reqs;

    csb_frame_ctl #(.FRAMES(FRAMES_PER_BLK)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .sf_valid  (sf_valid),
        .sf_second (sf_second),
        .blk_start (blk_start),
        .mode_in   (mode_sel),
        .sel_in    (sub_sel),
        .frame_idx (frame_idx),
        .mode_eff  (mode_eff),
        .sel_eff   (sel_eff),
        .active    (active),
        .blk_clr   (blk_clr),
        .done      (blk_done)
    );

    always_comb begin
        primary = (mode_eff == BM_DUAL_CS) ? ~sf_second : (sf_second == sel_eff);
        live    = sf_valid & active & (mode_eff != BM_RESERVED);
        csa_in_range = (mode_eff == BM_FULL_CS) ? (frame_idx <= LIM_FULL)
                                                : (frame_idx < LIM_SHORT);

        take[LANE_USER] = live & primary & (frame_idx < LIM_USER);
        take[LANE_CSA]  = live & primary & csa_in_range;
        take[LANE_CSB]  = live & (mode_eff == BM_DUAL_CS) & sf_second
                               & (frame_idx < LIM_SHORT);
        take[LANE_AUX]  = live & (mode_eff == BM_CS_AUX) & primary
                               & (frame_idx < LIM_AUX);

        lane_bit[LANE_USER] = u_bit;
        lane_bit[LANE_CSA]  = c_bit;
        lane_bit[LANE_CSB]  = c_bit;
        lane_bit[LANE_AUX]  = aux_bit;
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        csb_lane #(.BASE(lane_base(l))) u_lane (
            .clk      (clk),
            .rst      (rst),
            .clr      (blk_clr),
            .take     (take[l]),
            .bit_in   (lane_bit[l]),
            .bit_pos  (frame_idx[BITPOS_W-1:0]),
            .byte_idx (frame_idx[FRAME_W-1:BITPOS_W]),
            .wr       (reqs[l])
        );
    end

    csb_store u_store (
        .clk        (clk),
        .rst        (rst),
        .reqs       (reqs),
        .rd_addr    (rd_addr),
        .hide_upper (freq_cmp_en),
        .rd_data    (rd_data)
    );

    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == BM_RESERVED) |-> !(reqs[0].en || reqs[1].en || reqs[2].en || reqs[3].en));

    p_second_lane_dual_r5: assert property (@(posedge clk) disable iff (rst)
        reqs[LANE_CSB].en |-> (mode_eff == BM_DUAL_CS && sf_second));

    p_aux_lane_layout_r4: assert property (@(posedge clk) disable iff (rst)
        reqs[LANE_AUX].en |-> (mode_eff == BM_CS_AUX));

    p_no_write_unarmed_r10: assert property (@(posedge clk) disable iff (rst)
        !active |-> !(reqs[0].en || reqs[1].en || reqs[2].en || reqs[3].en));

endmodule

// File: tb/sim_csb_top.sv
`timescale 1ns/1ps
module sim_csb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       sf_valid, sf_second, blk_start;
    logic       c_bit, u_bit, aux_bit;
    logic [1:0] mode_sel;
    logic       sub_sel, freq_cmp_en;
    logic [4:0] rd_addr;
    logic [7:0] rd_data;
    logic       blk_done;

    always #2.5 clk = ~clk;

    csb_top u0 (
        .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_second(sf_second),
        .blk_start(blk_start), .c_bit(c_bit), .u_bit(u_bit), .aux_bit(aux_bit),
        .mode_sel(mode_sel), .sub_sel(sub_sel), .freq_cmp_en(freq_cmp_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .blk_done(blk_done)
    );

    typedef struct {
        int         addr;
        bit         fc;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    bit         mon_busy = 1'b0;
    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] model [32];

    function automatic bit gen_bit(int seed, int f, int sf, int kind);
        int h;
        h = seed * 97 + f * (kind + 5) + sf * 41 + (f * f) % 13 + kind * 11 + (f >> 3) * seed;
        return ((h * 7) % 11) > 4;
    endfunction

    // Expected buffer after a block of nframes (multiple of 8) with layout m, select s
    task automatic model_block(int seed, int m, int s, int nframes);
        for (int f = 0; f < nframes; f++) begin
            for (int sf = 0; sf < 2; sf++) begin
                bit prim;
                prim = (m == 2) ? (sf == 0) : (sf == s);
                if (m != 3) begin
                    if (prim && f < 32)  model[f/8][f%8] = gen_bit(seed, f, sf, 1);
                    if (prim && f < ((m == 0) ? 192 : 64))
                        model[8 + f/8][f%8] = gen_bit(seed, f, sf, 0);
                    if (m == 2 && sf == 1 && f < 64) model[16 + f/8][f%8] = gen_bit(seed, f, sf, 0);
                    if (m == 1 && prim && f < 128)   model[16 + f/8][f%8] = gen_bit(seed, f, sf, 2);
                end
            end
        end
    endtask

    task automatic check_done(logic exp, string tag);
        n_vec++;
        if (blk_done !== exp) begin
            n_bad++;
            $display("FAIL %s blk_done actual=%b expected=%b", tag, blk_done, exp);
        end
    endtask

    task automatic push_readback(bit fc, string tag);
        for (int a = 0; a < 32; a++) begin
            item_t it;
            it.addr = a;
            it.fc   = fc;
            it.exp  = fc ? model[a % 16] : model[a];
            it.tag  = tag;
            sb_q.push_back(it);
        end
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // Drives one (possibly partial) block: three cycles per frame
    task automatic run_block(int seed, int m, int s, int nframes, bit with_start,
                             bit mid_change, string dtag);
        @(negedge clk);
        mode_sel = 2'(m);
        sub_sel  = s[0];
        for (int f = 0; f < nframes; f++) begin
            if (mid_change && f == 10) begin
                mode_sel = ~2'(m);
                sub_sel  = ~s[0];
            end
            sf_valid  = 1'b1;
            sf_second = 1'b0;
            blk_start = with_start && (f == 0);
            c_bit = gen_bit(seed, f, 0, 0);
            u_bit = gen_bit(seed, f, 0, 1);
            aux_bit = gen_bit(seed, f, 0, 2);
            @(negedge clk);
            blk_start = 1'b0;
            sf_second = 1'b1;
            c_bit = gen_bit(seed, f, 1, 0);
            u_bit = gen_bit(seed, f, 1, 1);
            aux_bit = gen_bit(seed, f, 1, 2);
            @(negedge clk);
            sf_valid = 1'b0;
            check_done((f == 191 && nframes == 192 && with_start && m != 3), dtag);
            @(negedge clk);
            check_done(1'b0, "R9");
        end
        if (with_start) model_block(seed, m, s, nframes);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            @(negedge clk);
            rd_addr     = 5'(it.addr);
            freq_cmp_en = it.fc;
            #1;
            n_vec++;
            if (rd_data !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%0d fc=%0b actual=%02h expected=%02h",
                         it.tag, it.addr, it.fc, rd_data, it.exp);
            end
            mon_busy = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sf_valid = 0; sf_second = 0; blk_start = 0;
        c_bit = 0; u_bit = 0; aux_bit = 0;
        mode_sel = 0; sub_sel = 0; freq_cmp_en = 0; rd_addr = 0;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_done(1'b0, "R1");
        push_readback(1'b0, "R1");

        // Strobes with no block start write nothing
        run_block(11, 0, 0, 40, 1'b0, 1'b0, "R10");
        push_readback(1'b0, "R10");

        run_block(1, 0, 0, 192, 1'b1, 1'b0, "R9");
        push_readback(1'b0, "R3");
        run_block(2, 0, 1, 192, 1'b1, 1'b0, "R9");
        push_readback(1'b0, "R6");
        run_block(3, 1, 0, 192, 1'b1, 1'b0, "R9");
        push_readback(1'b0, "R4");
        run_block(4, 1, 1, 192, 1'b1, 1'b0, "R9");
        push_readback(1'b0, "R2");
        run_block(5, 2, 1, 192, 1'b1, 1'b0, "R9");
        push_readback(1'b0, "R5");
        run_block(6, 3, 0, 192, 1'b1, 1'b0, "R7");
        push_readback(1'b0, "R7");
        push_readback(1'b1, "R8");
        run_block(7, 2, 0, 48, 1'b1, 1'b0, "R10");
        run_block(8, 0, 1, 192, 1'b1, 1'b0, "R10");
        push_readback(1'b0, "R10");
        run_block(9, 1, 0, 192, 1'b1, 1'b1, "R11");
        push_readback(1'b0, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule